// File: doc/BRIEF.md
# Instruction Word Decoder

This block turns one 32-bit instruction word into the pieces an execution datapath needs in the same cycle. It splits the word into its opcode, three 5-bit register-address fields and an 11-bit function field. It extends the 16-bit immediate and the 26-bit jump offset to full data width. It also raises the control lines for the ALU, the register file, data memory, branching and jumping.

The decoder is purely combinational and holds no state. It picks the register that receives the result, which sits in a different field for register-register and register-immediate formats. The immediate is zero-extended for the bitwise and shift immediates and sign-extended for all others. Write enable is suppressed whenever the chosen destination is register zero. The register file, data memory and any hazard logic sit around the block and are not part of it.

Top module: `instr_decoder`

## Requirements
- R1: The opcode is bits 31..26, source A bits 25..21, source B bits 20..16, field C bits 15..11 and the function field bits 10..0; all five appear unmodified on their outputs.
- R2: Opcode 0x00 is register-register. The full 11-bit function value picks the ALU code: 0x20 add=0, 0x22 sub=1, 0x24 and=2, 0x25 or=3, 0x26 xor=4, 0x04 sll=5, 0x06 srl=6, 0x29 sne=7, 0x2c sle=8, 0x2d sge=9. The destination is field C, the immediate select is 0 and write enable is 1.
- R3: The immediate ALU opcodes are 0x08 add, 0x0a sub, 0x0c and, 0x0d or, 0x0e xor, 0x14 sll, 0x16 srl, 0x19 sne, 0x1c sle and 0x1d sge. They use the same ALU codes as R2, with the destination in source-B field, immediate select 1 and write enable 1.
- R4: For opcodes 0x0c, 0x0d, 0x0e, 0x14 and 0x16 the low 16 bits are zero-extended onto the immediate output. For every other word they are sign-extended.
- R5: Load (0x23) sets memory read, immediate select 1, ALU code 0 and writes the source-B field. Store (0x2b) sets memory write, immediate select 1 and ALU code 0, writes no register and reports destination 0.
- R6: Opcode 0x04 gives branch kind 1 (taken when register is zero) and opcode 0x05 gives branch kind 2 (taken when non-zero). Both write no register, touch no memory and report destination 0.
- R7: Opcode 0x02 raises jump only. Opcode 0x03 raises jump and link and writes register 31. The 26-bit offset is always sign-extended onto the jump offset output.
- R8: A no-op (0x15), an unlisted opcode or a register-register word with an unlisted function value leaves write enable, memory read/write, branch kind, jump and link all at 0, with ALU code 0.
- R9: Write enable is 0 whenever the reported destination is register 0.
- R10: At most one of memory read, memory write, a non-zero branch kind and jump is active for any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| opcode_o | output | 6 | Opcode field |
| src_a_o | output | 5 | First source register address |
| src_b_o | output | 5 | Second register field (source or immediate-format destination) |
| src_c_o | output | 5 | Third register field |
| func_o | output | 11 | Function field |
| dest_o | output | 5 | Selected destination register |
| imm_o | output | 32 | Extended 16-bit immediate |
| jofs_o | output | 32 | Sign-extended 26-bit jump offset |
| alu_op_o | output | 4 | ALU operation code |
| use_imm_o | output | 1 | ALU second operand is the immediate |
| reg_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| branch_o | output | 2 | Branch kind: 0 none, 1 if zero, 2 if non-zero |
| jump_o | output | 1 | Unconditional jump |
| link_o | output | 1 | Save return address in register 31 |

## Verification
The properties assume only that the instruction input is a settled two-state value, because the block has no clock and no handshake. Under that assumption, the exclusivity, register-zero and link properties hold for every possible word, including undefined opcodes and function values. The stimulus stays within this assumption: it changes the word once per clock period and compares the outputs half a period later. The stimulus covers every listed opcode, every listed function value, both destination fields set to zero, and unlisted codes in both the opcode and the function field.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int RADDR_W = 5;
  localparam int FUNC_W  = 11;
  localparam int IMM_W   = 16;
  localparam int JOFS_W  = 26;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_XOR = 4'd4, ALU_SLL = 4'd5, ALU_SRL = 4'd6, ALU_SNE = 4'd7,
    ALU_SLE = 4'd8, ALU_SGE = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0, BR_ZERO = 2'd1, BR_NONZERO = 2'd2
  } br_kind_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_FB = 2'd1, DST_FC = 2'd2, DST_LINK = 2'd3
  } dst_sel_e;

  // opcodes
  localparam logic [OPC_W-1:0] OP_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OP_J    = 6'h02;
  localparam logic [OPC_W-1:0] OP_JAL  = 6'h03;
  localparam logic [OPC_W-1:0] OP_BZ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_BNZ  = 6'h05;
  localparam logic [OPC_W-1:0] OP_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OP_SUBI = 6'h0a;
  localparam logic [OPC_W-1:0] OP_ANDI = 6'h0c;
  localparam logic [OPC_W-1:0] OP_ORI  = 6'h0d;
  localparam logic [OPC_W-1:0] OP_XORI = 6'h0e;
  localparam logic [OPC_W-1:0] OP_SLLI = 6'h14;
  localparam logic [OPC_W-1:0] OP_NOP  = 6'h15;
  localparam logic [OPC_W-1:0] OP_SRLI = 6'h16;
  localparam logic [OPC_W-1:0] OP_SNEI = 6'h19;
  localparam logic [OPC_W-1:0] OP_SLEI = 6'h1c;
  localparam logic [OPC_W-1:0] OP_SGEI = 6'h1d;
  localparam logic [OPC_W-1:0] OP_LD   = 6'h23;
  localparam logic [OPC_W-1:0] OP_ST   = 6'h2b;

  // function values for register-register words
  localparam logic [FUNC_W-1:0] FN_ADD = 11'h020;
  localparam logic [FUNC_W-1:0] FN_SUB = 11'h022;
  localparam logic [FUNC_W-1:0] FN_AND = 11'h024;
  localparam logic [FUNC_W-1:0] FN_OR  = 11'h025;
  localparam logic [FUNC_W-1:0] FN_XOR = 11'h026;
  localparam logic [FUNC_W-1:0] FN_SLL = 11'h004;
  localparam logic [FUNC_W-1:0] FN_SRL = 11'h006;
  localparam logic [FUNC_W-1:0] FN_SNE = 11'h029;
  localparam logic [FUNC_W-1:0] FN_SLE = 11'h02c;
  localparam logic [FUNC_W-1:0] FN_SGE = 11'h02d;

  typedef struct packed {
    alu_op_e  alu_op;
    logic     use_imm;
    logic     writes;
    dst_sel_e dst_sel;
    logic     mem_rd;
    logic     mem_wr;
    br_kind_e br;
    logic     jump;
    logic     link;
    logic     zext;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{alu_op: ALU_ADD, use_imm: 1'b0, writes: 1'b0,
                                  dst_sel: DST_NONE, mem_rd: 1'b0, mem_wr: 1'b0,
                                  br: BR_NONE, jump: 1'b0, link: 1'b0, zext: 1'b0};
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import instr_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OPC_W-1:0]   opcode_o,
  output logic [RADDR_W-1:0] fa_o,
  output logic [RADDR_W-1:0] fb_o,
  output logic [RADDR_W-1:0] fc_o,
  output logic [FUNC_W-1:0]  func_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int FA_LSB  = OPC_LSB - RADDR_W;
  localparam int FB_LSB  = FA_LSB - RADDR_W;
  localparam int FC_LSB  = FB_LSB - RADDR_W;

  assign opcode_o = instr_i[INSTR_W-1 -: OPC_W];
  assign fa_o     = instr_i[FA_LSB +: RADDR_W];
  assign fb_o     = instr_i[FB_LSB +: RADDR_W];
  assign fc_o     = instr_i[FC_LSB +: RADDR_W];
  assign func_o   = instr_i[FUNC_W-1:0];
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [FUNC_W-1:0] func_i,
  output ctrl_t             ctrl_o
);
  ctrl_t   c;
  alu_op_e reg_op;
  logic    reg_known;

  // register-register function decode
  always_comb begin
    reg_known = 1'b1;
    reg_op    = ALU_ADD;
    unique case (func_i)
      FN_ADD:  reg_op = ALU_ADD;
      FN_SUB:  reg_op = ALU_SUB;
      FN_AND:  reg_op = ALU_AND;
      FN_OR:   reg_op = ALU_OR;
      FN_XOR:  reg_op = ALU_XOR;
      FN_SLL:  reg_op = ALU_SLL;
      FN_SRL:  reg_op = ALU_SRL;
      FN_SNE:  reg_op = ALU_SNE;
      FN_SLE:  reg_op = ALU_SLE;
      FN_SGE:  reg_op = ALU_SGE;
      default: reg_known = 1'b0;
    endcase
  end

  // opcode decode
  always_comb begin
    c = CTRL_IDLE;
    unique case (opcode_i)
      OP_REG: begin
        c.dst_sel = DST_FC;
        if (reg_known) begin
          c.alu_op = reg_op;
          c.writes = 1'b1;
        end
      end
      OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_XORI,
      OP_SLLI, OP_SRLI, OP_SNEI, OP_SLEI, OP_SGEI: begin
        c.use_imm = 1'b1;
        c.writes  = 1'b1;
        c.dst_sel = DST_FB;
        unique case (opcode_i)
          OP_SUBI: c.alu_op = ALU_SUB;
          OP_ANDI: c.alu_op = ALU_AND;
          OP_ORI:  c.alu_op = ALU_OR;
          OP_XORI: c.alu_op = ALU_XOR;
          OP_SLLI: c.alu_op = ALU_SLL;
          OP_SRLI: c.alu_op = ALU_SRL;
          OP_SNEI: c.alu_op = ALU_SNE;
          OP_SLEI: c.alu_op = ALU_SLE;
          OP_SGEI: c.alu_op = ALU_SGE;
          default: c.alu_op = ALU_ADD;
        endcase
        c.zext = (opcode_i == OP_ANDI) || (opcode_i == OP_ORI) ||
                 (opcode_i == OP_XORI) || (opcode_i == OP_SLLI) ||
                 (opcode_i == OP_SRLI);
      end
      OP_LD: begin
        c.use_imm = 1'b1;
        c.writes  = 1'b1;
        c.dst_sel = DST_FB;
        c.mem_rd  = 1'b1;
      end
      OP_ST: begin
        c.use_imm = 1'b1;
        c.mem_wr  = 1'b1;
      end
      OP_BZ:   c.br = BR_ZERO;
      OP_BNZ:  c.br = BR_NONZERO;
      OP_J:    c.jump = 1'b1;
      OP_JAL: begin
        c.jump    = 1'b1;
        c.link    = 1'b1;
        c.writes  = 1'b1;
        c.dst_sel = DST_LINK;
      end
      default: c = CTRL_IDLE;
    endcase
  end

  assign ctrl_o = c;
endmodule

// File: rtl/idec_imm.sv
module idec_imm
  import instr_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [JOFS_W-1:0] raw_i,
  input  logic              zext_i,
  output logic [DATA_W-1:0] imm_o,
  output logic [DATA_W-1:0] jofs_o
);
  localparam int IMM_PAD  = DATA_W - IMM_W;
  localparam int JOFS_PAD = DATA_W - JOFS_W;

  logic imm_fill;
  assign imm_fill = raw_i[IMM_W-1] & ~zext_i;
  assign imm_o    = {{IMM_PAD{imm_fill}}, raw_i[IMM_W-1:0]};
  assign jofs_o   = {{JOFS_PAD{raw_i[JOFS_W-1]}}, raw_i};
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LINK_REG = 31
) (
  input  logic [31:0]     instr_i,
  output logic [5:0]      opcode_o,
  output logic [4:0]      src_a_o,
  output logic [4:0]      src_b_o,
  output logic [4:0]      src_c_o,
  output logic [10:0]     func_o,
  output logic [4:0]      dest_o,
  output logic [DATA_W-1:0] imm_o,
  output logic [DATA_W-1:0] jofs_o,
  output logic [3:0]      alu_op_o,
  output logic            use_imm_o,
  output logic            reg_we_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [1:0]      branch_o,
  output logic            jump_o,
  output logic            link_o
);
  localparam logic [RADDR_W-1:0] LINK_ADDR = RADDR_W'(LINK_REG);

  logic [OPC_W-1:0]   opc;
  logic [RADDR_W-1:0] fa, fb, fc;
  logic [FUNC_W-1:0]  fn;
  ctrl_t              ctl;
  logic [RADDR_W-1:0] dst;

  idec_fields u_fields (
    .instr_i (instr_i),
    .opcode_o(opc),
    .fa_o    (fa),
    .fb_o    (fb),
    .fc_o    (fc),
    .func_o  (fn)
  );

  idec_ctrl u_ctrl (
    .opcode_i(opc),
    .func_i  (fn),
    .ctrl_o  (ctl)
  );

  idec_imm #(.DATA_W(DATA_W)) u_imm (
    .raw_i (instr_i[JOFS_W-1:0]),
    .zext_i(ctl.zext),
    .imm_o (imm_o),
    .jofs_o(jofs_o)
  );

  always_comb begin
    unique case (ctl.dst_sel)
      DST_FB:   dst = fb;
      DST_FC:   dst = fc;
      DST_LINK: dst = LINK_ADDR;
      default:  dst = '0;
    endcase
  end

  assign opcode_o  = opc;
  assign src_a_o   = fa;
  assign src_b_o   = fb;
  assign src_c_o   = fc;
  assign func_o    = fn;
  assign dest_o    = dst;
  assign alu_op_o  = ctl.alu_op;
  assign use_imm_o = ctl.use_imm;
  assign reg_we_o  = ctl.writes & (dst != '0);
  assign mem_rd_o  = ctl.mem_rd;
  assign mem_wr_o  = ctl.mem_wr;
  assign branch_o  = ctl.br;
  assign jump_o    = ctl.jump;
  assign link_o    = ctl.link;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int DATA_W = 32
) (
  input logic [4:0]        dest_o,
  input logic [DATA_W-1:0] imm_o,
  input logic [3:0]        alu_op_o,
  input logic              reg_we_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [1:0]        branch_o,
  input logic              jump_o,
  input logic              link_o
);
  always_comb begin
    a_r9_no_write_r0: assert (!(reg_we_o && dest_o == 5'd0));
    a_r10_one_effect: assert ($countones({mem_rd_o, mem_wr_o, branch_o != 2'd0, jump_o}) <= 1);
    a_r5_store_no_write: assert (!mem_wr_o || (!reg_we_o && dest_o == 5'd0));
    a_r7_link_dest: assert (!link_o || (jump_o && reg_we_o && dest_o == 5'd31));
    a_r6_branch_quiet: assert (branch_o == 2'd0 || (!reg_we_o && !jump_o && branch_o != 2'd3));
    a_r4_ext_fill: assert (imm_o[DATA_W-1:16] == '0 || imm_o[DATA_W-1:15] == '1);
    a_r2_alu_range: assert (alu_op_o <= 4'd9);
  end
endmodule

bind instr_decoder instr_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .dest_o  (dest_o),
  .imm_o   (imm_o),
  .alu_op_o(alu_op_o),
  .reg_we_o(reg_we_o),
  .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o),
  .branch_o(branch_o),
  .jump_o  (jump_o),
  .link_o  (link_o)
);

// File: tb/instr_decoder_bench.sv
module instr_decoder_bench;
  logic clk;
  logic rst_n;
  logic [31:0] instr;
  logic [5:0]  opcode;
  logic [4:0]  sa, sb, sc, dest;
  logic [10:0] func;
  logic [31:0] imm, jofs;
  logic [3:0]  alu_op;
  logic        use_imm, reg_we, mem_rd, mem_wr, jump, link;
  logic [1:0]  branch;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  instr_decoder u_instr_decoder (
    .instr_i(instr), .opcode_o(opcode), .src_a_o(sa), .src_b_o(sb),
    .src_c_o(sc), .func_o(func), .dest_o(dest), .imm_o(imm), .jofs_o(jofs),
    .alu_op_o(alu_op), .use_imm_o(use_imm), .reg_we_o(reg_we),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .branch_o(branch),
    .jump_o(jump), .link_o(link)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] rr(input int a, input int b, input int d, input int f);
    return {6'h00, 5'(a), 5'(b), 5'(d), 11'(f)};
  endfunction
  function automatic logic [31:0] ri(input int op, input int a, input int d, input int im);
    return {6'(op), 5'(a), 5'(d), 16'(im)};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [3:0]  rq;
    logic [3:0]  op;
    logic        ui;
    logic        we;
    logic [4:0]  dst;
    logic        mrd;
    logic        mwr;
    logic [1:0]  br;
    logic        jmp;
    logic        lnk;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{rr(20,10,9,'h20), 4'd2, 4'd0, 1'b0, 1'b1, 5'd9,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(12,15,6,'h22), 4'd2, 4'd1, 1'b0, 1'b1, 5'd6,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(3,10,9,'h24),  4'd2, 4'd2, 1'b0, 1'b1, 5'd9,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(3,4,5,'h25),   4'd2, 4'd3, 1'b0, 1'b1, 5'd5,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(12,15,6,'h26), 4'd2, 4'd4, 1'b0, 1'b1, 5'd6,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(2,3,1,'h04),   4'd2, 4'd5, 1'b0, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(7,8,5,'h06),   4'd2, 4'd6, 1'b0, 1'b1, 5'd5,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(2,3,1,'h29),   4'd2, 4'd7, 1'b0, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(2,4,13,'h2c),  4'd2, 4'd8, 1'b0, 1'b1, 5'd13, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(2,10,1,'h2d),  4'd2, 4'd9, 1'b0, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h08,2,1,-5),  4'd3, 4'd0, 1'b1, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h0a,9,7,-30), 4'd3, 4'd1, 1'b1, 1'b1, 5'd7,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h0c,9,20,8),  4'd3, 4'd2, 1'b1, 1'b1, 5'd20, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h0d,3,5,342), 4'd3, 4'd3, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h0e,12,6,1),  4'd3, 4'd4, 1'b1, 1'b1, 5'd6,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h14,1,4,5),   4'd3, 4'd5, 1'b1, 1'b1, 5'd4,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h16,5,7,2),   4'd3, 4'd6, 1'b1, 1'b1, 5'd7,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h19,5,3,4),   4'd3, 4'd7, 1'b1, 1'b1, 5'd3,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h1c,3,1,-4),  4'd3, 4'd8, 1'b1, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h1d,20,9,6),  4'd3, 4'd9, 1'b1, 1'b1, 5'd9,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h23,8,19,63), 4'd5, 4'd0, 1'b1, 1'b1, 5'd19, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h2b,2,1,1),   4'd5, 4'd0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    '{ri('h04,12,0,-18),4'd6, 4'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
    '{ri('h05,2,7,-30), 4'd6, 4'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
    '{32'h0BFF_FF3C,    4'd7, 4'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    '{32'h0FFF_FF3C,    4'd7, 4'd0, 1'b0, 1'b1, 5'd31, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
    '{ri('h15,0,0,0),   4'd8, 4'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h15,7,9,77),  4'd8, 4'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h3f,4,6,12),  4'd8, 4'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(2,3,4,'h21),   4'd8, 4'd0, 1'b0, 1'b0, 5'd4,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(2,3,4,'h420),  4'd8, 4'd0, 1'b0, 1'b0, 5'd4,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{ri('h08,1,0,5),   4'd9, 4'd0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{rr(5,6,0,'h22),   4'd9, 4'd1, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0}
  };

  function automatic string rq_name(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (instr %h)", req, act, exp, instr);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    instr = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: all-zero word during reset targets register 0
    check("R9", {31'd0, reg_we}, 32'd0);
    check("R9", {27'd0, dest}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].ins);
      check(rq_name(VEC[i].rq),
            {15'd0, alu_op, use_imm, reg_we, dest, mem_rd, mem_wr, branch, jump, link},
            {15'd0, VEC[i].op, VEC[i].ui, VEC[i].we, VEC[i].dst, VEC[i].mrd,
             VEC[i].mwr, VEC[i].br, VEC[i].jmp, VEC[i].lnk});
      // R10: exclusive side effects
      check("R10", {31'd0, ($countones({mem_rd, mem_wr, branch != 2'd0, jump}) > 1)}, 32'd0);
    end

    // R1: field positions
    apply(32'hA5A5_5A5A);
    check("R1", {26'd0, opcode}, 32'h29);
    check("R1", {27'd0, sa}, 32'h0D);
    check("R1", {27'd0, sb}, 32'h05);
    check("R1", {27'd0, sc}, 32'h0B);
    check("R1", {21'd0, func}, 32'h25A);

    // R4: zero versus sign extension
    apply(ri('h0c, 1, 2, 'h8000));  check("R4", imm, 32'h0000_8000);
    apply(ri('h0d, 1, 2, 'hFFFF));  check("R4", imm, 32'h0000_FFFF);
    apply(ri('h0e, 1, 2, 'h9000));  check("R4", imm, 32'h0000_9000);
    apply(ri('h14, 1, 2, 'hFFF0));  check("R4", imm, 32'h0000_FFF0);
    apply(ri('h16, 1, 2, 'h8001));  check("R4", imm, 32'h0000_8001);
    apply(ri('h08, 2, 1, -5));      check("R4", imm, 32'hFFFF_FFFB);
    apply(ri('h1c, 3, 1, -4));      check("R4", imm, 32'hFFFF_FFFC);
    apply(ri('h23, 8, 3, 'hFFFF));  check("R4", imm, 32'hFFFF_FFFF);
    apply(ri('h2b, 8, 3, 'h7FFF));  check("R4", imm, 32'h0000_7FFF);
    apply(ri('h05, 2, 0, -30));     check("R4", imm, 32'hFFFF_FFE2);

    // R7: jump offset extension
    apply(32'h0BFF_FF3C);           check("R7", jofs, 32'hFFFF_FF3C);
    apply(32'h0C00_0100);           check("R7", jofs, 32'h0000_0100);
    check("R7", {27'd0, dest}, 32'd31);
    apply(32'h0A00_0000 | 32'h0200_0000); check("R7", jofs, 32'hFE00_0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule